// File: doc/BRIEF.md
# Panel Power-Up and Identity Probe Controller

This block wakes a small LCD driver chip and confirms that the expected part is fitted. After a one-cycle `start` pulse it moves two active-low pins, a protect line and a reset line, through a timed sequence. It then uses a narrow command/parameter bus to clear write protection and bring the chip out of deep standby. Next it sends the identity command, waits, and reads the identity code back.

The bus has a register-select bit that is low for a command and high for a parameter or a read. It also has separate one-cycle write and read strobes, an outgoing data word and an incoming data word. Five reads follow the identity command. The first is a throw-away read. The low byte of each of the other four fills the 32-bit code, most significant byte first. The code is compared with a parameter.

When the sequence ends, `done` pulses and exactly one of `present` or `absent` is set. Every wait is a counter whose length is derived from the `CLK_HZ` parameter. The same RTL therefore serves a fast system clock and a slow test clock.

Top module: `panel_probe_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release until a start, `busy`, `done`, `present`, `absent`, `bus_wr`, `bus_rd` and `bus_rs` are 0, `bus_dout` is 0, and `lcd_prot_n` and `lcd_rst_n` are 1.
- R2: A start accepted at clock edge S drives `lcd_prot_n` low at edge S+1, `lcd_rst_n` low at S+2 and `lcd_prot_n` high at S+3. `lcd_rst_n` rises exactly D(1100 us) cycles later while `lcd_prot_n` is still high. `lcd_prot_n` falls exactly D(10 us) cycles after that and then stays low.
- R3: The first bus strobe is asserted exactly D(20000 us) cycles after the final fall of `lcd_prot_n`. No strobe occurs unless `lcd_rst_n` is high and `lcd_prot_n` is low.
- R4: Each strobe lasts one cycle and is followed by at least one cycle with both strobes low. The strobes are never high together. A command write has `bus_rs`=0, the command in `bus_dout[7:0]` and zeros above it. A parameter write and a read have `bus_rs`=1.
- R5: The writes, in order, are: command 0xB0, parameter 0x00, command 0xB1, parameter 0x00, command 0xBF. There are no other writes.
- R6: The first read strobe comes at least D(50000 us) and at most D(50000 us)+4 cycles after the 0xBF command strobe. Exactly five read strobes follow.
- R7: The data of the first read is discarded. Reads two to five supply code bits [31:24], [23:16], [15:8] and [7:0] from `bus_din[7:0]`. `bus_din` bits above bit 7 are ignored.
- R8: `present` is set when the code equals `EXPECT_CODE` (default 0x01221517), and `absent` is set otherwise. The flag holds until the next accepted start. No bus strobe follows `done`.
- R9: `busy` rises the cycle after an accepted start and stays high until the cycle in which `done` is high. `busy` is low in that cycle. `done` is high for exactly one cycle per run.
- R10: A `start` pulse while `busy` is high is ignored: the write and read counts, the result and the single `done` pulse are unchanged.
- R11: D(t) is the cycle count ceil(`CLK_HZ`·t / 10^6), with a minimum of 1. With `CLK_HZ`=200000 this gives 220, 2, 4000 and 10000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the run ends |
| present | output | 1 | Identity code matched |
| absent | output | 1 | Identity code did not match |
| lcd_prot_n | output | 1 | Active-low protect pin of the panel |
| lcd_rst_n | output | 1 | Active-low reset pin of the panel |
| bus_rs | output | 1 | Register select: 0 command, 1 parameter or read |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe; `bus_din` is sampled at the end of that cycle |
| bus_dout | output | DATA_W | Outgoing command or parameter |
| bus_din | input | DATA_W | Read data from the panel |

## Verification
If the pin sequencer takes a wrong step, it shows at once as a pin edge at the wrong cycle. Any error in a delay counter moves the reset release, the protect fall or the first bus strobe by a measurable number of cycles. A bus step counter that skips or repeats a step shows within one access as a wrong command byte, a missing parameter or a sixth read. A fault in code assembly, such as a kept dummy read, a wrong byte order or upper data bits leaking in, only shows at `done`, as `absent` where `present` was due, so the read patterns are chosen to tell these faults apart.

// File: rtl/panel_probe_pkg.sv
package panel_probe_pkg;

  localparam int unsigned T_HOLD_US    = 1100;
  localparam int unsigned T_REL_US     = 10;
  localparam int unsigned T_SETTLE_US  = 20000;
  localparam int unsigned T_ID_WAIT_US = 50000;

  localparam logic [7:0] CMD_UNLOCK  = 8'hB0;
  localparam logic [7:0] CMD_WAKE    = 8'hB1;
  localparam logic [7:0] CMD_READ_ID = 8'hBF;

  localparam logic [3:0] STEP_DUMMY = 4'd6;
  localparam logic [3:0] STEP_LAST  = 4'd10;

  typedef enum logic [1:0] {OP_CMD, OP_PAR, OP_WAIT, OP_READ} op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [7:0] val;
  } op_t;

  // ceil(hz * us / 1e6), never zero
  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // bus program: the order matters to the panel
  function automatic op_t step_op(input logic [3:0] s);
    op_t o;
    case (s)
      4'd0:    o = '{kind: OP_CMD,  val: CMD_UNLOCK};
      4'd1:    o = '{kind: OP_PAR,  val: 8'h00};
      4'd2:    o = '{kind: OP_CMD,  val: CMD_WAKE};
      4'd3:    o = '{kind: OP_PAR,  val: 8'h00};
      4'd4:    o = '{kind: OP_CMD,  val: CMD_READ_ID};
      4'd5:    o = '{kind: OP_WAIT, val: 8'h00};
      default: o = '{kind: OP_READ, val: 8'h00};
    endcase
    return o;
  endfunction

  function automatic logic keeps_byte(input logic [3:0] s);
    return (s > STEP_DUMMY) && (s <= STEP_LAST);
  endfunction

endpackage

// File: rtl/probe_delay.sv
module probe_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  // the edge with cnt==1 is the value-th edge after load
  assign expired = (cnt == W'(1));
endmodule

// File: rtl/probe_pins.sv
module probe_pins
  import panel_probe_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic lcd_prot_n,
  output logic lcd_rst_n,
  output logic seq_done
);
  localparam int unsigned N_HOLD   = us_to_cycles(CLK_HZ, T_HOLD_US);
  localparam int unsigned N_REL    = us_to_cycles(CLK_HZ, T_REL_US);
  localparam int unsigned N_SETTLE = us_to_cycles(CLK_HZ, T_SETTLE_US);
  localparam int unsigned N_MAX    = (N_SETTLE > N_HOLD) ? N_SETTLE : N_HOLD;
  localparam int DW = width_for(N_MAX);

  typedef enum logic [2:0] {PS_IDLE, PS_A, PS_B, PS_HOLD, PS_REL, PS_SETTLE} pstate_e;
  pstate_e ps;

  logic          dly_load;
  logic [DW-1:0] dly_val;
  logic          dly_exp;

  probe_delay #(.W(DW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .value(dly_val), .expired(dly_exp)
  );

  always_comb begin
    dly_load = 1'b0;
    dly_val  = '0;
    case (ps)
      PS_B:    begin dly_load = 1'b1;    dly_val = DW'(N_HOLD);   end
      PS_HOLD: begin dly_load = dly_exp; dly_val = DW'(N_REL);    end
      PS_REL:  begin dly_load = dly_exp; dly_val = DW'(N_SETTLE); end
      default: ;
    endcase
  end

  assign seq_done = (ps == PS_SETTLE) && dly_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps         <= PS_IDLE;
      lcd_prot_n <= 1'b1;
      lcd_rst_n  <= 1'b1;
    end else begin
      case (ps)
        PS_IDLE:   if (go) begin lcd_prot_n <= 1'b0; ps <= PS_A; end
        PS_A:      begin lcd_rst_n <= 1'b0; ps <= PS_B; end
        PS_B:      begin lcd_prot_n <= 1'b1; ps <= PS_HOLD; end
        PS_HOLD:   if (dly_exp) begin lcd_rst_n <= 1'b1; ps <= PS_REL; end
        PS_REL:    if (dly_exp) begin lcd_prot_n <= 1'b0; ps <= PS_SETTLE; end
        PS_SETTLE: if (dly_exp) ps <= PS_IDLE;
        default:   ps <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/probe_bus.sv
module probe_bus
  import panel_probe_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              bus_rs,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  output logic              seq_done,
  output logic [31:0]       code
);
  localparam int unsigned N_WAIT = us_to_cycles(CLK_HZ, T_ID_WAIT_US);
  localparam int DW = width_for(N_WAIT);

  logic       active;
  logic [3:0] step;
  logic       half;     // 0: strobe cycle, 1: recovery / wait cycle
  op_t        op;
  logic       dly_load;
  logic       dly_exp;
  logic       advance;
  logic       unused_din;

  assign unused_din = ^bus_din[DATA_W-1:8];
  assign op = step_op(step);

  probe_delay #(.W(DW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .value(DW'(N_WAIT)), .expired(dly_exp)
  );

  assign bus_wr   = active && !half && (op.kind == OP_CMD || op.kind == OP_PAR);
  assign bus_rd   = active && !half && (op.kind == OP_READ);
  assign bus_rs   = active && (op.kind == OP_PAR || op.kind == OP_READ);
  assign bus_dout = bus_wr ? DATA_W'(op.val) : '0;
  assign dly_load = active && !half && (op.kind == OP_WAIT);
  assign advance  = active && half && (op.kind != OP_WAIT || dly_exp);
  assign seq_done = advance && (step == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      half   <= 1'b0;
      code   <= '0;
    end else if (go) begin
      active <= 1'b1;
      step   <= '0;
      half   <= 1'b0;
      code   <= '0;
    end else if (active) begin
      if (!half) begin
        half <= 1'b1;
        if (op.kind == OP_READ && keeps_byte(step))
          code <= {code[23:0], bus_din[7:0]};
      end
      if (advance) begin
        half <= 1'b0;
        step <= step + 4'd1;
        if (step == STEP_LAST) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/panel_probe_ctrl.sv
module panel_probe_ctrl
  import panel_probe_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int DATA_W = 18,
  parameter logic [31:0] EXPECT_CODE = 32'h0122_1517
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              present,
  output logic              absent,
  output logic              lcd_prot_n,
  output logic              lcd_rst_n,
  output logic              bus_rs,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  typedef enum logic [1:0] {T_IDLE, T_PINS, T_BUS} tstate_e;
  tstate_e state;

  // named internal events, visible to the bound checker
  logic        pins_go;
  logic        pins_done;
  logic        bus_go;
  logic        bus_done;
  logic        code_match;
  logic [31:0] probe_code;

  assign pins_go    = start && (state == T_IDLE);
  assign bus_go     = (state == T_PINS) && pins_done;
  assign code_match = (probe_code == EXPECT_CODE);
  assign busy       = (state != T_IDLE);

  probe_pins #(.CLK_HZ(CLK_HZ)) u_pins (
    .clk(clk), .rst_n(rst_n), .go(pins_go),
    .lcd_prot_n(lcd_prot_n), .lcd_rst_n(lcd_rst_n), .seq_done(pins_done)
  );

  probe_bus #(.CLK_HZ(CLK_HZ), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(bus_go),
    .bus_rs(bus_rs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_dout(bus_dout), .bus_din(bus_din),
    .seq_done(bus_done), .code(probe_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= T_IDLE;
      done    <= 1'b0;
      present <= 1'b0;
      absent  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        T_IDLE: if (start) begin
          state   <= T_PINS;
          present <= 1'b0;
          absent  <= 1'b0;
        end
        T_PINS: if (pins_done) state <= T_BUS;
        T_BUS:  if (bus_done) begin
          state   <= T_IDLE;
          done    <= 1'b1;
          present <= code_match;
          absent  <= !code_match;
        end
        default: state <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_probe_chk.sv
module panel_probe_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              present,
  input logic              absent,
  input logic              lcd_prot_n,
  input logic              lcd_rst_n,
  input logic              bus_rs,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_dout,
  input logic              pins_done,
  input logic              bus_done
);
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  a_r4_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));

  a_r4_cmd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rs) |-> ((bus_dout >> 8) == '0));

  a_r4_read_selects_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_rs);

  a_r3_bus_after_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> (lcd_rst_n && !lcd_prot_n));

  a_r2_release_while_protected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_rst_n) |-> lcd_prot_n);

  a_r3_pins_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    pins_done |-> (busy && lcd_rst_n && !lcd_prot_n));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_follows_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_done));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(present && absent));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(start && !busy) && !bus_done) |=> ($stable(present) && $stable(absent)));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !bus_done) |=> busy);
endmodule

bind panel_probe_ctrl panel_probe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .present(present), .absent(absent), .lcd_prot_n(lcd_prot_n),
  .lcd_rst_n(lcd_rst_n), .bus_rs(bus_rs), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_dout(bus_dout), .pins_done(pins_done), .bus_done(bus_done)
);

// File: tb/sim_panel_probe_ctrl.sv
`timescale 1ns/1ps
module sim_panel_probe_ctrl;
  localparam longint unsigned HZ = 200_000;
  localparam int DW = 18;

  // own restatement of the delay rule: (kHz * us) / 1000 rounded up
  function automatic int cyc_for(input int us);
    int v;
    v = (int'(HZ / 1000) * us + 999) / 1000;
    return (v < 1) ? 1 : v;
  endfunction

  localparam int E_HOLD = 220, E_REL = 2, E_SETTLE = 4000, E_WAIT = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] bus_din = '0;
  logic busy, done, present, absent, lcd_prot_n, lcd_rst_n, bus_rs, bus_wr, bus_rd;
  logic [DW-1:0] bus_dout;

  always #10 clk = ~clk;

  panel_probe_ctrl #(.CLK_HZ(HZ), .DATA_W(DW), .EXPECT_CODE(32'h0122_1517)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .present(present), .absent(absent), .lcd_prot_n(lcd_prot_n),
    .lcd_rst_n(lcd_rst_n), .bus_rs(bus_rs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  int runs = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  int wr_n, rd_n, t_bf, t_rd1, t_first_stb, gap_err, hi_err, rs_err, done_cnt, busy_at_done;
  int t_prot_fall_first, t_prot_fall_last, t_prot_rise, t_rst_fall, t_rst_rise, prot_falls;
  logic [7:0] wr_val [16];
  logic       wr_rs  [16];
  logic [DW-1:0] rd_vals [5];
  logic prev_prot = 1'b1, prev_rst = 1'b1, prev_stb = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_prot_n !== prev_prot) begin
        if (!lcd_prot_n) begin
          if (prot_falls == 0) t_prot_fall_first = cyc;
          t_prot_fall_last = cyc;
          prot_falls++;
        end else t_prot_rise = cyc;
      end
      if (lcd_rst_n !== prev_rst) begin
        if (!lcd_rst_n) t_rst_fall = cyc; else t_rst_rise = cyc;
      end
      if ((bus_wr || bus_rd) && prev_stb) gap_err++;
      if ((bus_wr || bus_rd) && t_first_stb < 0) t_first_stb = cyc;
      if (bus_wr) begin
        if (wr_n < 16) begin wr_val[wr_n] = bus_dout[7:0]; wr_rs[wr_n] = bus_rs; end
        if (!bus_rs && bus_dout[7:0] == 8'hBF) t_bf = cyc;
        if (!bus_rs && bus_dout[DW-1:8] != '0) hi_err++;
        wr_n++;
      end
      if (bus_rd) begin
        if (rd_n == 0) t_rd1 = cyc;
        if (!bus_rs) rs_err++;
        bus_din = rd_vals[(rd_n < 5) ? rd_n : 4];
        rd_n++;
      end
      if (done) begin
        done_cnt++;
        if (busy) busy_at_done++;
      end
      prev_prot = lcd_prot_n;
      prev_rst  = lcd_rst_n;
      prev_stb  = bus_wr || bus_rd;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_log();
    wr_n = 0; rd_n = 0; t_bf = -1; t_rd1 = -1; t_first_stb = -1;
    gap_err = 0; hi_err = 0; rs_err = 0; done_cnt = 0; busy_at_done = 0;
    t_prot_fall_first = -1; t_prot_fall_last = -1; t_prot_rise = -1;
    t_rst_fall = -1; t_rst_rise = -1; prot_falls = 0;
  endtask

  // runs one probe; start accepted at the edge following t_start
  task automatic run_probe(input logic [DW-1:0] v0, v1, v2, v3, v4,
                           input bit poke_busy, output int t_start);
    int guard;
    rd_vals[0] = v0; rd_vals[1] = v1; rd_vals[2] = v2; rd_vals[3] = v3; rd_vals[4] = v4;
    @(negedge clk);
    clear_log();
    t_start = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    guard = 0;
    while (done !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (poke_busy && (guard == 40 || guard == 9000)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done === 1'b1, "R9 run completes", guard, 0);
    chk(busy === 1'b0, "R9 busy low with done", busy, 0);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(busy_at_done == 0, "R9 busy low at done", busy_at_done, 0);
  endtask

  task automatic check_bus_program();
    logic [7:0] ev [5];
    logic       er [5];
    ev = '{8'hB0, 8'h00, 8'hB1, 8'h00, 8'hBF};
    er = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    chk(wr_n == 5, "R5 write count (R8 none after done)", wr_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk(wr_val[i] == ev[i], "R5 write value", wr_val[i], ev[i]);
      chk(wr_rs[i] == er[i], "R4 register select on write", wr_rs[i], er[i]);
    end
    chk(rd_n == 5, "R6 read count", rd_n, 5);
    chk(gap_err == 0, "R4 strobe gap", gap_err, 0);
    chk(hi_err == 0, "R4 command upper bits", hi_err, 0);
    chk(rs_err == 0, "R4 read register select", rs_err, 0);
    chk(t_rd1 - t_bf >= E_WAIT && t_rd1 - t_bf <= E_WAIT + 4,
        "R6 identity wait", t_rd1 - t_bf, E_WAIT);
  endtask

  task automatic check_pins(input int s, input bit first_run);
    if (first_run)
      chk(t_prot_fall_first == s + 1, "R2 protect first fall", t_prot_fall_first, s + 1);
    chk(t_rst_fall == s + 2, "R2 reset fall", t_rst_fall, s + 2);
    chk(t_prot_rise == s + 3, "R2 protect rise", t_prot_rise, s + 3);
    chk(t_rst_rise == s + 3 + E_HOLD, "R2 R11 reset release hold", t_rst_rise, s + 3 + E_HOLD);
    chk(t_prot_fall_last == t_rst_rise + E_REL, "R2 R11 protect fall after release",
        t_prot_fall_last, t_rst_rise + E_REL);
    chk(lcd_prot_n === 1'b0 && lcd_rst_n === 1'b1, "R2 final pin levels",
        {lcd_prot_n, lcd_rst_n}, 2'b01);
    chk(t_first_stb == t_prot_fall_last + E_SETTLE, "R3 R11 settle before bus",
        t_first_stb, t_prot_fall_last + E_SETTLE);
  endtask

  task automatic t_reset();
    chk(busy === 0 && done === 0 && present === 0 && absent === 0, "R1 flags in reset",
        {busy, done, present, absent}, 0);
    chk(lcd_prot_n === 1 && lcd_rst_n === 1, "R1 pins in reset", {lcd_prot_n, lcd_rst_n}, 3);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(bus_wr === 0 && bus_rd === 0 && bus_rs === 0 && bus_dout === '0, "R1 bus idle",
        {bus_wr, bus_rd, bus_rs}, 0);
    chk(busy === 0 && present === 0 && absent === 0, "R1 idle flags", {busy, present, absent}, 0);
    chk(cyc_for(1100) == E_HOLD && cyc_for(10) == E_REL && cyc_for(20000) == E_SETTLE
        && cyc_for(50000) == E_WAIT, "R11 bench delay table", cyc_for(10), E_REL);
  endtask

  task automatic t_match();
    int s;
    run_probe(18'h003A5, 18'h00001, 18'h00022, 18'h00015, 18'h00017, 1'b0, s);
    check_pins(s, 1'b1);
    check_bus_program();
    chk(present === 1 && absent === 0, "R8 match gives present", {present, absent}, 2'b10);
  endtask

  task automatic t_upper_bits();
    int s;
    run_probe(18'h3FFFF, 18'h3FF01, 18'h2AA22, 18'h15515, 18'h3C017, 1'b0, s);
    check_pins(s, 1'b0);
    chk(present === 1 && absent === 0, "R7 upper data bits ignored", {present, absent}, 2'b10);
  endtask

  task automatic t_dummy_discard();
    int s;
    run_probe(18'h00001, 18'h00022, 18'h00015, 18'h00017, 18'h00000, 1'b0, s);
    check_bus_program();
    chk(present === 0 && absent === 1, "R7 dummy read discarded", {present, absent}, 2'b01);
  endtask

  task automatic t_wrong_code();
    int s;
    run_probe(18'h00000, 18'h00001, 18'h00022, 18'h00015, 18'h00018, 1'b0, s);
    chk(present === 0 && absent === 1, "R8 mismatch gives absent", {present, absent}, 2'b01);
    repeat (50) @(negedge clk);
    chk(absent === 1 && wr_n == 5 && rd_n == 5, "R8 absent holds, bus quiet", absent, 1);
  endtask

  task automatic t_start_busy();
    int s;
    run_probe(18'h00000, 18'h00001, 18'h00022, 18'h00015, 18'h00017, 1'b1, s);
    check_pins(s, 1'b0);
    check_bus_program();
    chk(prot_falls == 1, "R10 no pin restart", prot_falls, 1);
    chk(present === 1, "R10 result unchanged", present, 1);
  endtask

  initial begin
    clear_log();
    rd_vals = '{default: '0};
    repeat (3) @(negedge clk);
    t_reset();
    t_match();
    t_upper_bits();
    t_dummy_discard();
    t_wrong_code();
    t_start_busy();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    runs++; fails++;
    $display("[TB] FAIL watchdog: actual %0d cycles, expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule